// File: doc/BRIEF.md
# Rotary Shaft Encoder Decoder

This block turns the three raw pins of a mechanical rotary knob into clean control events. The knob has two cam contacts, A and B, that pull their pins low while closed and let them read high while open, plus a push switch on the shaft that reads high while pressed. None of the pins has hardware debouncing, and each contact bounces for a couple of milliseconds around every change.

Every raw pin passes through a two-flop synchroniser and then a stability filter. The filter accepts a new level only after it has held without interruption for `DEBOUNCE_CYCLES` clocks (default 250000, five milliseconds at 50 MHz). A state machine follows the filtered contact pair through one detent. Leaving rest, whichever contact closes first fixes the direction. The machine emits a single `step` pulse with `dir` when both contacts are open again. For the push switch the block gives the filtered level and a one-cycle `press` pulse on each filtered rising edge.

Decoder states: REST (both open), LEAD_A / LEAD_B (only A, or only B, closed after rest), BOTH_A / BOTH_B (both closed, direction remembered), TAIL_A / TAIL_B (one contact reopened after both were closed), LOST (waiting for both open after a jump that skipped a position). Transitions: REST to LEAD_A or LEAD_B when one contact closes. LEAD to BOTH when the second contact closes, and LEAD back to REST when the first contact reopens. BOTH to TAIL when either contact opens. TAIL back to BOTH when it closes again. TAIL to REST when both are open, and this move fires `step`. A jump is a sample in which both filtered contacts change at once. From REST, LEAD or TAIL a jump leads to LOST. From BOTH a jump leads to REST without a step. LOST goes to REST once both contacts are open.

Top module: `rotary_decoder`

## Requirements
- R1: Each raw pin reaches the filter through two synchronising flops; a push-pin change held steady from one clock to the next is seen on `held` exactly `DEBOUNCE_CYCLES`+2 rising edges after it is applied.
- R2: A pin change that reverts before `DEBOUNCE_CYCLES` clocks have passed is discarded: `held`, `press` and `step` stay as they were, and two changes of a filtered level are at least `DEBOUNCE_CYCLES` clocks apart.
- R3: `press` is high for exactly one clock, in the same clock that `held` goes from 0 to 1; a falling `held` gives no pulse.
- R4: With pair notation {A,B} and 0 meaning closed, the sequence 11, 01, 00, 10, 11 (A closes first) gives exactly one `step` with `dir`=1; `step` lasts one clock and `dir` changes only together with a step.
- R5: The sequence 11, 10, 00, 01, 11 (B closes first) gives exactly one `step` with `dir`=0.
- R6: A rotation that closes one contact and reopens it before the other closes (11, 01, 11 or 11, 10, 11) gives no step.
- R7: When both filtered contacts change in the same sample, no step is emitted for that sequence; after a jump out of rest, the decoder ignores the pins until both are open again and then decodes normally.
- R8: While reset is applied and just after it, `step`, `dir`, `press` and `held` are 0.
- R9: Moving back and forth between the both-closed position and a one-open position inside one detent still yields exactly one step, with the direction set by the contact that closed first.
- R10: `step` is only ever high while both filtered contacts are open.
- R11: A press and a step that fall in the same clock are both delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_a | input | 1 | Contact A pin, low while closed |
| raw_b | input | 1 | Contact B pin, low while closed |
| raw_push | input | 1 | Shaft push pin, high while pressed |
| step | output | 1 | One-clock pulse per completed detent |
| dir | output | 1 | Direction of the last step, 1 when A closed first |
| press | output | 1 | One-clock pulse on a filtered press |
| held | output | 1 | Filtered push switch level |

## Verification
The detent step and the push-switch press come from independent filter chains, so they can land in the same clock. The bench provokes this by releasing the contacts to the open state and pressing the shaft one clock later, because the step path has one more register than the press path. It judges the result by checking that the monitor saw a clock with both pulses high and that the step and press totals each went up by one. Random detents with injected short bounces in both directions run against a bench model of expected step counts and directions.

// File: rtl/rotenc_pkg.sv
package rotenc_pkg;

    typedef enum logic [2:0] {
        ST_REST   = 3'd0,
        ST_LEAD_A = 3'd1,
        ST_LEAD_B = 3'd2,
        ST_BOTH_A = 3'd3,
        ST_BOTH_B = 3'd4,
        ST_TAIL_A = 3'd5,
        ST_TAIL_B = 3'd6,
        ST_LOST   = 3'd7
    } dec_state_t;

    // Contact pair {A,B}; 0 means the contact is closed
    localparam logic [1:0] PAIR_OPEN   = 2'b11;
    localparam logic [1:0] PAIR_SHUT   = 2'b00;
    localparam logic [1:0] PAIR_A_SHUT = 2'b01;
    localparam logic [1:0] PAIR_B_SHUT = 2'b10;

    localparam int PIN_A    = 0;
    localparam int PIN_B    = 1;
    localparam int PIN_PUSH = 2;
    localparam int NUM_PINS = 3;

endpackage

// File: rtl/pin_sync2.sv
module pin_sync2 #(
    parameter int WIDTH = 3,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/bounce_filter.sv
module bounce_filter #(
    parameter int   LIMIT     = 250000,
    parameter logic RESET_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rose
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          level_q;
    logic          rose_q;
    logic          differs;

    assign differs = (din != level_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= RESET_LVL;
            rose_q  <= 1'b0;
        end else begin
            rose_q <= 1'b0;
            if (!differs) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q   <= '0;
                level_q <= din;
                rose_q  <= din;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level = level_q;
    assign rose  = rose_q;

endmodule

// File: rtl/detent_fsm.sv
module detent_fsm
    import rotenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_a,
    input  logic lvl_b,
    output logic step,
    output logic dir
);

    dec_state_t state_q, state_d;
    logic [1:0] pair;
    logic [1:0] prev_q;
    logic       jump;
    logic       fire;
    logic       fire_dir;
    logic       step_q;
    logic       dir_q;

    assign pair = {lvl_a, lvl_b};
    assign jump = ((pair ^ prev_q) == 2'b11);

    always_comb begin
        state_d  = state_q;
        fire     = 1'b0;
        fire_dir = 1'b0;
        unique case (state_q)
            ST_REST: begin
                if (jump)                     state_d = ST_LOST;
                else if (pair == PAIR_A_SHUT) state_d = ST_LEAD_A;
                else if (pair == PAIR_B_SHUT) state_d = ST_LEAD_B;
            end
            ST_LEAD_A: begin
                if (jump)                     state_d = ST_LOST;
                else if (pair == PAIR_OPEN)   state_d = ST_REST;
                else if (pair == PAIR_SHUT)   state_d = ST_BOTH_A;
            end
            ST_LEAD_B: begin
                if (jump)                     state_d = ST_LOST;
                else if (pair == PAIR_OPEN)   state_d = ST_REST;
                else if (pair == PAIR_SHUT)   state_d = ST_BOTH_B;
            end
            ST_BOTH_A: begin
                if (jump)                     state_d = ST_REST;
                else if (pair != PAIR_SHUT)   state_d = ST_TAIL_A;
            end
            ST_BOTH_B: begin
                if (jump)                     state_d = ST_REST;
                else if (pair != PAIR_SHUT)   state_d = ST_TAIL_B;
            end
            ST_TAIL_A: begin
                if (jump)                     state_d = ST_LOST;
                else if (pair == PAIR_SHUT)   state_d = ST_BOTH_A;
                else if (pair == PAIR_OPEN) begin
                    state_d  = ST_REST;
                    fire     = 1'b1;
                    fire_dir = 1'b1;
                end
            end
            ST_TAIL_B: begin
                if (jump)                     state_d = ST_LOST;
                else if (pair == PAIR_SHUT)   state_d = ST_BOTH_B;
                else if (pair == PAIR_OPEN) begin
                    state_d  = ST_REST;
                    fire     = 1'b1;
                    fire_dir = 1'b0;
                end
            end
            ST_LOST: begin
                if (pair == PAIR_OPEN)        state_d = ST_REST;
            end
            default:                          state_d = ST_REST;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_REST;
            prev_q  <= PAIR_OPEN;
        end else begin
            state_q <= state_d;
            prev_q  <= pair;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            step_q <= fire;
            if (fire) dir_q <= fire_dir;
        end
    end

    assign step = step_q;
    assign dir  = dir_q;

endmodule

// File: rtl/rotary_decoder.sv
module rotary_decoder
    import rotenc_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_a,
    input  logic raw_b,
    input  logic raw_push,
    output logic step,
    output logic dir,
    output logic press,
    output logic held
);

    // Contacts rest open (high), push rests released (low)
    localparam logic [NUM_PINS-1:0] RST_LVL = 3'b011;

    logic [NUM_PINS-1:0] raw_vec;
    logic [NUM_PINS-1:0] sync_vec;
    logic [NUM_PINS-1:0] lvl_vec;
    logic [NUM_PINS-1:0] rise_vec;
    logic                deb_a;
    logic                deb_b;

    assign raw_vec = {raw_push, raw_b, raw_a};

    pin_sync2 #(
        .WIDTH (NUM_PINS),
        .INIT  (RST_LVL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (sync_vec)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_filt
        bounce_filter #(
            .LIMIT     (DEBOUNCE_CYCLES),
            .RESET_LVL (RST_LVL[i])
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sync_vec[i]),
            .level (lvl_vec[i]),
            .rose  (rise_vec[i])
        );
    end

    assign deb_a = lvl_vec[PIN_A];
    assign deb_b = lvl_vec[PIN_B];

    detent_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_a (deb_a),
        .lvl_b (deb_b),
        .step  (step),
        .dir   (dir)
    );

    assign held  = lvl_vec[PIN_PUSH];
    assign press = rise_vec[PIN_PUSH];

endmodule

// File: rtl/rotary_checks.sv
module rotary_checks #(
    parameter int DEBOUNCE_CYCLES = 250000
) (
    input logic clk,
    input logic rst_n,
    input logic step,
    input logic dir,
    input logic press,
    input logic held,
    input logic deb_a,
    input logic deb_b
);

    localparam int GW = $clog2(DEBOUNCE_CYCLES + 1) + 1;
    localparam logic [GW-1:0] GAP_MAX = GW'(DEBOUNCE_CYCLES);
    localparam logic [GW-1:0] GAP_MIN = GW'(DEBOUNCE_CYCLES - 1);

    logic          held_d;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_d <= 1'b0;
            gap_q  <= '0;
        end else begin
            held_d <= held;
            if (held != held_d) gap_q <= '0;
            else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
        end
    end

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step); // R4
    AST_DIR_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dir != $past(dir)) |-> step); // R4
    AST_STEP_BOTH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (deb_a && deb_b)); // R10
    AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press); // R3
    AST_PRESS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> $rose(held)); // R3
    AST_RISE_GIVES_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> press); // R3
    AST_LEVEL_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
        (held != held_d) |-> (gap_q >= GAP_MIN)); // R2

endmodule

bind rotary_decoder rotary_checks #(
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
) u_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .dir   (dir),
    .press (press),
    .held  (held),
    .deb_a (deb_a),
    .deb_b (deb_b)
);

// File: tb/tb_rotary_decoder.sv
module tb_rotary_decoder;

    localparam int LIMIT  = 8;
    localparam int SETTLE = LIMIT + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_a = 1'b1;
    logic raw_b = 1'b1;
    logic raw_push = 1'b0;
    logic step, dir, press, held;

    int n_checks = 0;
    int n_fail = 0;
    int n_steps = 0;
    int n_press = 0;
    int n_both = 0;
    logic last_dir = 1'b0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rotary_decoder #(.DEBOUNCE_CYCLES(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .raw_a(raw_a), .raw_b(raw_b),
        .raw_push(raw_push), .step(step), .dir(dir), .press(press), .held(held)
    );

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (step) begin n_steps++; last_dir = dir; end
            if (press) n_press++;
            if (step && press) n_both++;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic set_pair(input logic a, input logic b);
        @(negedge clk);
        raw_a = a;
        raw_b = b;
        repeat (SETTLE) @(negedge clk);
    endtask

    // Short glitch on one contact, shorter than the filter window
    task automatic glitch(input int which, input int len);
        @(negedge clk);
        if (which == 0) raw_a = ~raw_a; else raw_b = ~raw_b;
        repeat (len) @(negedge clk);
        if (which == 0) raw_a = ~raw_a; else raw_b = ~raw_b;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [1:0] lead_pair(input logic d);
        return d ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] tail_pair(input logic d);
        return d ? 2'b10 : 2'b01;
    endfunction

    task automatic detent(input logic d, input bit bouncy);
        logic [1:0] p;
        p = lead_pair(d);
        if (bouncy) glitch(d ? 0 : 1, 1 + int'($urandom % (LIMIT - 2)));
        set_pair(p[1], p[0]);
        if (bouncy) glitch(d ? 1 : 0, 1 + int'($urandom % (LIMIT - 2)));
        set_pair(1'b0, 1'b0);
        p = tail_pair(d);
        set_pair(p[1], p[0]);
        set_pair(1'b1, 1'b1);
    endtask

    initial begin : watchdog
        while (!done && cycles < 150000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog got %0d expected %0d", cycles, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int exp_steps;
        int exp_press;
        logic exp_dir;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check("R8 step in reset", step, 0);
        check("R8 press in reset", press, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 dir after reset", dir, 0);
        check("R8 held after reset", held, 0);
        repeat (4) @(negedge clk);

        // R1: exact latency of push level
        @(negedge clk);
        raw_push = 1'b1;
        repeat (LIMIT + 1) @(posedge clk);
        #2 check("R1 held before latency", held, 0);
        @(posedge clk);
        #2 check("R1 held at latency", held, 1);
        repeat (SETTLE) @(negedge clk);
        check("R3 one press on rise", n_press, 1);
        raw_push = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R3 no press on fall", n_press, 1);
        check("R3 held low again", held, 0);

        // R2: short glitches ignored
        @(negedge clk);
        raw_push = 1'b1;
        repeat (LIMIT - 2) @(negedge clk);
        raw_push = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R2 push glitch held", held, 0);
        check("R2 push glitch press", n_press, 1);
        glitch(0, LIMIT - 2);
        glitch(1, LIMIT - 2);
        repeat (SETTLE) @(negedge clk);
        check("R2 contact glitch step", n_steps, 0);

        // R4: A leads
        detent(1'b1, 1'b0);
        check("R4 cw count", n_steps, 1);
        check("R4 cw dir", last_dir, 1);
        check("R4 dir held", dir, 1);

        // R5: B leads
        detent(1'b0, 1'b0);
        check("R5 ccw count", n_steps, 2);
        check("R5 ccw dir", last_dir, 0);

        // R6: abandoned starts
        set_pair(1'b0, 1'b1);
        set_pair(1'b1, 1'b1);
        set_pair(1'b1, 1'b0);
        set_pair(1'b1, 1'b1);
        check("R6 abandoned no step", n_steps, 2);

        // R9: dither inside a detent
        set_pair(1'b0, 1'b1);
        set_pair(1'b0, 1'b0);
        set_pair(1'b1, 1'b0);
        set_pair(1'b0, 1'b0);
        set_pair(1'b1, 1'b0);
        set_pair(1'b0, 1'b0);
        set_pair(1'b1, 1'b0);
        set_pair(1'b1, 1'b1);
        check("R9 dither one step", n_steps, 3);
        check("R9 dither dir", last_dir, 1);

        // R7: jump out of rest, then LOST until open
        set_pair(1'b0, 1'b0);
        set_pair(1'b1, 1'b0);
        set_pair(1'b1, 1'b1);
        check("R7 jump from rest no step", n_steps, 3);
        // jump from both-closed back to open
        set_pair(1'b1, 1'b0);
        set_pair(1'b0, 1'b0);
        set_pair(1'b1, 1'b1);
        check("R7 jump to open no step", n_steps, 3);
        // jump across in tail
        set_pair(1'b0, 1'b1);
        set_pair(1'b0, 1'b0);
        set_pair(1'b1, 1'b0);
        set_pair(1'b0, 1'b1);
        set_pair(1'b1, 1'b1);
        check("R7 jump in tail no step", n_steps, 3);
        detent(1'b0, 1'b0);
        check("R7 recovers count", n_steps, 4);
        check("R7 recovers dir", last_dir, 0);

        // R11: step and press in the same clock
        set_pair(1'b0, 1'b1);
        set_pair(1'b0, 1'b0);
        set_pair(1'b1, 1'b0);
        @(negedge clk);
        raw_a = 1'b1;
        raw_b = 1'b1;
        @(negedge clk);
        raw_push = 1'b1;
        repeat (SETTLE) @(negedge clk);
        check("R11 coincident cycle seen", n_both, 1);
        check("R11 step delivered", n_steps, 5);
        check("R11 press delivered", n_press, 2);
        raw_push = 1'b0;
        repeat (SETTLE) @(negedge clk);

        // Random detents with bounce, abandoned starts and presses
        exp_steps = n_steps;
        exp_press = n_press;
        for (int k = 0; k < 40; k++) begin
            int kind;
            kind = int'($urandom % 4);
            exp_dir = logic'($urandom % 2);
            if (kind == 0) begin
                logic [1:0] p;
                p = lead_pair(exp_dir);
                set_pair(p[1], p[0]);
                set_pair(1'b1, 1'b1);
                check("R6 random abandoned", n_steps, exp_steps);
            end else begin
                detent(exp_dir, 1'b1);
                exp_steps++;
                check(exp_dir ? "R4 random count" : "R5 random count", n_steps, exp_steps);
                check(exp_dir ? "R4 random dir" : "R5 random dir", last_dir, exp_dir);
            end
            if (kind == 3) begin
                @(negedge clk);
                raw_push = 1'b1;
                repeat (SETTLE) @(negedge clk);
                raw_push = 1'b0;
                repeat (SETTLE) @(negedge clk);
                exp_press++;
                check("R3 random press", n_press, exp_press);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule